// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Sequencer

This block sits between a simple synchronous host port and an asynchronous DRAM with a 4-bit data bus and a shared row/column address bus. The host asks for one word at a time: it raises `reqValid` with a direction flag, a 22-bit word address and, for writes, 4 bits of data, and keeps them steady until `reqAck` pulses. The sequencer then plays out a complete strobe sequence. It places the row half of the address, lowers the row strobe, switches the bus to the column half and lowers the column strobe together with either the output enable (read) or the write enable (write). It holds the strobes for long enough and then releases both strobes at once. Finally it waits out the precharge gap before it accepts another request.

Every minimum DRAM timing is a parameter counted in clock cycles. The controller derives from these parameters how long each phase lasts. Read data is captured only once the access times from the row strobe, the column address, the column strobe and the output enable have all elapsed. Only single accesses are supported. Page bursts, refresh and power-up sequencing are left to other blocks.

Top module: `dram_access_seq`

## Requirements
- R1: While reset is held and directly after it, all four strobes (`memRasN`, `memCasN`, `memWeN`, `memOeN`) are high, `memDqOe` is low and `reqAck` is low.
- R2: The row half `reqAddr[21:11]` is on `memAddr` in the cycle the row strobe falls. The column half `reqAddr[10:0]` is on `memAddr` in the cycle the column strobe falls and stays unchanged while the column strobe is low.
- R3: The column strobe is low only while the row strobe is low. An access ends by raising the row and column strobes in the same cycle.
- R4: The row strobe stays low for at least `T_RAS` cycles in every access.
- R5: Between accesses the row strobe stays high for at least `T_RP` cycles and the column strobe for at least `T_CP` cycles.
- R6: In a read, `memWeN` stays high and `memOeN` falls with the column strobe. The word on `memDqIn` is captured at a clock edge at least `T_RAC` cycles after the row strobe fell, `T_AA` cycles after the column address appeared, and `T_CAC` and `T_OE` cycles after the column strobe and output enable fell. It appears on `rspRdata` by the cycle `reqAck` is high.
- R7: In a write, `memDqOut` carries the request's data and `memDqOe` is high before the column strobe and write enable fall, and both stay that way while the write enable is low. `memOeN` stays high.
- R8: `memDqOe` is never high in a read access, and `memOeN` and `memWeN` are never low together.
- R9: A request is taken only when the sequencer is idle. Each request gets exactly one `reqAck` pulse, one cycle long, after the strobes have been released. Reading an address returns the data most recently written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request pending; held until `reqAck` |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 22 | Word address, row in the upper 11 bits |
| reqWdata | input | 4 | Write data |
| reqAck | output | 1 | One-cycle completion pulse |
| rspRdata | output | 4 | Read data, valid with `reqAck` |
| memAddr | output | 11 | Multiplexed DRAM address |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 1 | Column strobe, active low |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memDqOut | output | 4 | Data driven to DRAM |
| memDqOe | output | 1 | Enable for `memDqOut` onto the data pins |
| memDqIn | input | 4 | Data returned by DRAM |

## Verification
The embedded assertions check on every cycle the rules that concern only the strobes and the bus. These are: the column strobe falls only under a low row strobe, both strobes rise together, the output enable and write enable are exclusive, write data is driven whenever the write enable is low, the column address is stable under the column strobe, the row strobe's minimum low time is met, and the acknowledge is a single pulse. The bench's DRAM model is needed to show that the capture edge respects all four access times: it returns corrupted data until each timing is met. The model also checks that the row and column halves land where they should, that the precharge gaps hold under back-to-back requests, and that data written to an address comes back from it.

// File: rtl/dram_access_seq_pkg.sv
package dram_access_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_ROW, S_RAS, S_COL, S_CAS, S_PRE
  } seqState_t;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic loadReq;     // latch host request
    logic selCol;      // column half onto memAddr
    logic driveData;   // enable write data onto DRAM pins
    logic captureData; // sample memDqIn
  } pathCtl_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_access_seq_ctrl.sv
module dram_access_seq_ctrl
  import dram_access_seq_pkg::*;
#(
  parameter int T_RCD = 2,
  parameter int T_RAS = 7,
  parameter int T_RP  = 3,
  parameter int T_CP  = 1,
  parameter int T_RAC = 8,
  parameter int T_AA  = 3,
  parameter int T_CAC = 2,
  parameter int T_OE  = 2,
  parameter int T_WRL = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqWrite,
  output logic     reqAck,
  output logic     rasN,
  output logic     casN,
  output logic     weN,
  output logic     oeN,
  output pathCtl_t pathCtl
);

  // Cycles the column strobe stays low, derived from the access times
  localparam int RAS_FILL = T_RAS - T_RCD - 1;
  localparam int RD_NEED  = maxOf(maxOf(T_CAC, T_OE), maxOf(T_AA - 1, T_RAC - T_RCD - 1));
  localparam int RD_LEN   = maxOf(maxOf(RD_NEED, RAS_FILL), 1);
  localparam int WR_LEN   = maxOf(maxOf(T_WRL, RAS_FILL), 1);
  localparam int PRE_LEN  = maxOf(maxOf(T_RP - 2, T_CP - T_RCD - 3), 1);
  localparam int RCD_LEN  = maxOf(T_RCD, 1);
  localparam int CNT_MAX  = maxOf(maxOf(RD_LEN, WR_LEN), maxOf(PRE_LEN, RCD_LEN));
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  localparam logic [CNT_W-1:0] RCD_END = CNT_W'(RCD_LEN - 1);
  localparam logic [CNT_W-1:0] RD_END  = CNT_W'(RD_LEN - 1);
  localparam logic [CNT_W-1:0] WR_END  = CNT_W'(WR_LEN - 1);
  localparam logic [CNT_W-1:0] PRE_END = CNT_W'(PRE_LEN - 1);

  seqState_t        state;
  logic [CNT_W-1:0] phaseCnt;
  logic             wrQ;
  logic [CNT_W-1:0] casEnd;

  assign casEnd = wrQ ? WR_END : RD_END;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      phaseCnt <= '0;
      wrQ      <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (reqValid) begin
          state <= S_ROW;
          wrQ   <= reqWrite;
        end
        S_ROW: begin
          state    <= S_RAS;
          phaseCnt <= '0;
        end
        S_RAS: if (phaseCnt == RCD_END) state <= S_COL;
               else phaseCnt <= phaseCnt + 1'b1;
        S_COL: begin
          state    <= S_CAS;
          phaseCnt <= '0;
        end
        S_CAS: if (phaseCnt == casEnd) begin
          state    <= S_PRE;
          phaseCnt <= '0;
        end else phaseCnt <= phaseCnt + 1'b1;
        S_PRE: if (phaseCnt == PRE_END) state <= S_IDLE;
               else phaseCnt <= phaseCnt + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    rasN   = !(state inside {S_RAS, S_COL, S_CAS});
    casN   = (state != S_CAS);
    weN    = !((state == S_CAS) && wrQ);
    oeN    = !((state == S_CAS) && !wrQ);
    reqAck = (state == S_PRE) && (phaseCnt == '0);
    pathCtl.loadReq     = (state == S_IDLE) && reqValid;
    pathCtl.selCol      = state inside {S_COL, S_CAS};
    pathCtl.driveData   = wrQ && (state inside {S_COL, S_CAS});
    pathCtl.captureData = (state == S_CAS) && !wrQ && (phaseCnt == RD_END);
  end

  // Checker-only counter: cycles the row strobe has been low
  logic [7:0] rasLowCyc;
  always_ff @(posedge clk) begin
    if (!rstN || rasN) rasLowCyc <= '0;
    else if (rasLowCyc != 8'hFF) rasLowCyc <= rasLowCyc + 1'b1;
  end

  // R3
  cas_needs_ras_chk: assert property (@(posedge clk) disable iff (!rstN)
    !casN |-> !rasN);
  // R3
  ras_rise_with_cas_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> casN);
  // R4
  ras_min_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> (int'(rasLowCyc) >= T_RAS));
  // R8
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!oeN && !weN));
  // R9
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);

endmodule

// File: rtl/dram_access_seq_path.sv
module dram_access_seq_path
  import dram_access_seq_pkg::*;
#(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 11,
  parameter int DATA_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  pathCtl_t                 pathCtl,
  input  logic [ROW_W+COL_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  input  logic [DATA_W-1:0]        memDqIn,
  output logic [DATA_W-1:0]        rspRdata,
  output logic [DATA_W-1:0]        memDqOut,
  output logic                     memDqOe,
  output logic [ROW_W-1:0]         memAddr
);

  localparam int ADDR_W = ROW_W + COL_W;
  localparam int BUS_W  = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic [BUS_W-1:0]  rowBus;
  logic [BUS_W-1:0]  colBus;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (pathCtl.loadReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (pathCtl.captureData) rdataQ <= memDqIn;
    end
  end

  assign rowBus   = BUS_W'(addrQ[ADDR_W-1:COL_W]);
  assign colBus   = BUS_W'(addrQ[COL_W-1:0]);
  assign memAddr  = ROW_W'(pathCtl.selCol ? colBus : rowBus);
  assign memDqOut = wdataQ;
  assign memDqOe  = pathCtl.driveData;
  assign rspRdata = rdataQ;

endmodule

// File: rtl/dram_access_seq.sv
module dram_access_seq
  import dram_access_seq_pkg::*;
#(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 11,
  parameter int DATA_W = 4,
  parameter int T_RCD  = 2,
  parameter int T_RAS  = 7,
  parameter int T_RP   = 3,
  parameter int T_CP   = 1,
  parameter int T_RAC  = 8,
  parameter int T_AA   = 3,
  parameter int T_CAC  = 2,
  parameter int T_OE   = 2,
  parameter int T_WRL  = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic                   reqWrite,
  input  logic [ROW_W+COL_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]      reqWdata,
  output logic                   reqAck,
  output logic [DATA_W-1:0]      rspRdata,
  output logic [ROW_W-1:0]       memAddr,
  output logic                   memRasN,
  output logic                   memCasN,
  output logic                   memWeN,
  output logic                   memOeN,
  output logic [DATA_W-1:0]      memDqOut,
  output logic                   memDqOe,
  input  logic [DATA_W-1:0]      memDqIn
);

  pathCtl_t pathCtl;

  dram_access_seq_ctrl #(
    .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_CP(T_CP), .T_RAC(T_RAC),
    .T_AA(T_AA), .T_CAC(T_CAC), .T_OE(T_OE), .T_WRL(T_WRL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAck(reqAck), .rasN(memRasN), .casN(memCasN), .weN(memWeN),
    .oeN(memOeN), .pathCtl(pathCtl)
  );

  dram_access_seq_path #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)
  ) u_path (
    .clk(clk), .rstN(rstN), .pathCtl(pathCtl), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .memDqIn(memDqIn), .rspRdata(rspRdata),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memAddr(memAddr)
  );

  // R7
  drive_under_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memDqOe);
  // R2
  col_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memCasN && $past(!memCasN)) |-> $stable(memAddr));
  // R8
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memDqOe);

endmodule

// File: tb/dram_access_seq_tb.sv
module dram_access_seq_tb;

  localparam int T_RCD = 2, T_RAS = 7, T_RP = 3, T_CP = 1;
  localparam int T_RAC = 8, T_AA = 3, T_CAC = 2, T_OE = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [21:0] reqAddr = '0;
  logic [3:0]  reqWdata = '0;
  logic        reqAck;
  logic [3:0]  rspRdata;
  logic [10:0] memAddr;
  logic        memRasN, memCasN, memWeN, memOeN, memDqOe;
  logic [3:0]  memDqOut, memDqIn;

  always #4 clk = ~clk;  // 125 MHz

  dram_access_seq u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqAck(reqAck),
    .rspRdata(rspRdata), .memAddr(memAddr), .memRasN(memRasN),
    .memCasN(memCasN), .memWeN(memWeN), .memOeN(memOeN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  int checkCnt = 0, failCnt = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  // ---------------- DRAM model ----------------
  logic [3:0]  store  [int];
  logic [3:0]  refMem [int];
  logic [21:0] expAddr = '0;
  logic [3:0]  expWdata = '0;
  int rasCnt = 0, casCnt = 0, oeCnt = 0, addrAge = 0;
  int rasHigh = 100, casHigh = 100;
  logic prevRas = 1'b1, prevCas = 1'b1, wrSeen = 1'b0;
  logic [10:0] lastAddr = '0, rowLatch = '0, colLatch = '0;
  logic [3:0]  cellVal;
  logic        dataReady;

  assign cellVal   = store.exists({rowLatch, colLatch}) ? store[{rowLatch, colLatch}] : 4'h0;
  assign dataReady = (rasCnt >= T_RAC) && (addrAge >= T_AA) &&
                     (casCnt >= T_CAC) && (oeCnt >= T_OE);
  assign memDqIn   = (!memCasN && !memOeN && memWeN && dataReady) ? cellVal : ~cellVal;

  always @(negedge clk) begin
    if (rstN) begin
      if (memAddr != lastAddr) addrAge = 1; else addrAge = addrAge + 1;
      lastAddr = memAddr;
      if (!memRasN) begin
        if (prevRas) begin
          rowLatch = memAddr;
          // R2 row half present when row strobe falls
          check(memAddr == expAddr[21:11], "R2 row address", memAddr, expAddr[21:11]);
          // R5 row precharge gap
          check(rasHigh >= T_RP, "R5 row strobe high time", rasHigh, T_RP);
          rasCnt = 0;
        end
        rasCnt = rasCnt + 1;
      end else begin
        if (!prevRas) begin
          // R4 row strobe minimum low time
          check(rasCnt >= T_RAS, "R4 row strobe low time", rasCnt, T_RAS);
          // R3 both strobes released together
          check(memCasN, "R3 column strobe high at row release", memCasN, 1);
          rasHigh = 0;
        end
        rasHigh = rasHigh + 1;
      end
      if (!memCasN) begin
        if (prevCas) begin
          colLatch = memAddr;
          check(memAddr == expAddr[10:0], "R2 column address", memAddr, expAddr[10:0]);
          check(!memRasN, "R3 column strobe under row strobe", memRasN, 0);
          check(casHigh >= T_CP, "R5 column strobe high time", casHigh, T_CP);
          if (memWeN) begin
            // R6 read: output enable with column strobe; R8 no drive
            check(!memOeN, "R6 output enable low with column strobe", memOeN, 0);
            check(!memDqOe, "R8 data enable off in read", memDqOe, 0);
          end
          casCnt = 0;
        end
        casCnt = casCnt + 1;
        if (!memOeN) oeCnt = oeCnt + 1;
        if (!memWeN && !wrSeen) begin
          wrSeen = 1'b1;
          // R7 write data driven at the write launch
          check(memDqOe && memOeN, "R7 data enable at write", {memDqOe, memOeN}, 3);
          check(memDqOut == expWdata, "R7 write data", memDqOut, expWdata);
          store[{rowLatch, colLatch}] = memDqOut;
        end
      end else begin
        if (!prevCas) casHigh = 0;
        casHigh = casHigh + 1;
        casCnt = 0; oeCnt = 0; wrSeen = 1'b0;
      end
      prevRas = memRasN;
      prevCas = memCasN;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct { bit isWrite; logic [3:0] data; } item_t;
  item_t expQ[$];

  always @(negedge clk) begin
    if (rstN && reqAck) begin
      if (expQ.size() == 0) begin
        check(0, "R9 acknowledge without request", 1, 0);
      end else begin
        item_t it;
        it = expQ.pop_front();
        if (!it.isWrite)
          check(rspRdata == it.data, "R6 read data", rspRdata, it.data);
      end
    end
  end

  task automatic access(input bit wr, input logic [21:0] addr,
                        input logic [3:0] data, input int gap);
    item_t it;
    repeat (gap) @(negedge clk);
    it.isWrite = wr;
    it.data    = wr ? data : (refMem.exists(int'(addr)) ? refMem[int'(addr)] : 4'h0);
    expQ.push_back(it);
    if (wr) refMem[int'(addr)] = data;
    expAddr  = addr;
    expWdata = data;
    reqWrite = wr;
    reqAddr  = addr;
    reqWdata = data;
    reqValid = 1'b1;
    do @(negedge clk); while (!reqAck);
    reqValid = 1'b0;
  endtask

  // watchdog
  int wdCnt = 0;
  always @(posedge clk) begin
    wdCnt++;
    if (wdCnt > 100000) begin
      check(0, "watchdog expired", wdCnt, 100000);
      finishRun();
    end
  end

  logic [21:0] addrs [8];

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check({memRasN, memCasN, memWeN, memOeN} == 4'hF, "R1 strobes in reset",
          {memRasN, memCasN, memWeN, memOeN}, 4'hF);
    check(!memDqOe && !reqAck, "R1 data enable and ack in reset", {memDqOe, reqAck}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check({memRasN, memCasN, memWeN, memOeN} == 4'hF, "R1 strobes after reset",
          {memRasN, memCasN, memWeN, memOeN}, 4'hF);

    addrs[0] = 22'h000001; addrs[1] = 22'h3FFFFE; addrs[2] = 22'h155AAA;
    addrs[3] = 22'h2AA555; addrs[4] = 22'h000800; addrs[5] = 22'h3FF800;
    addrs[6] = 22'h0007FF; addrs[7] = 22'h123456;

    // writes with idle gaps, then reads back
    for (int i = 0; i < 8; i++) access(1'b1, addrs[i], 4'(i * 3 + 1), 2);
    for (int i = 0; i < 8; i++) access(1'b0, addrs[i], 4'h0, 1);

    // back-to-back chain: minimum precharge spacing (R5)
    for (int i = 0; i < 8; i++) access(1'b1, addrs[i], ~4'(i), 0);
    for (int i = 7; i >= 0; i--) access(1'b0, addrs[i], 4'h0, 0);

    // overwrite then read, and a never-written address (R9)
    access(1'b1, addrs[2], 4'hF, 0);
    access(1'b1, addrs[2], 4'h0, 0);
    access(1'b0, addrs[2], 4'h0, 0);
    access(1'b0, 22'h0ABCDE, 4'h0, 3);

    // R9 single acknowledge: none while idle after the last request
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!reqAck, "R9 no acknowledge while idle", reqAck, 0);
    end
    check(expQ.size() == 0, "R9 every request acknowledged", expQ.size(), 0);
    finishRun();
  end

endmodule